// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a three-wire link to a 12-bit differential successive-approximation converter. On a command it lowers chip select, which starts the conversion, and produces sixteen serial clock pulses by dividing the system clock. On each falling serial clock edge it takes one bit from the converter's data line. Each frame carries four zero bits ahead of the result, and the controller checks them. It then assembles the 12 result bits, most significant first. The result is a signed two's-complement code, which the block sign-extends onto a 16-bit bus and marks with a one-cycle valid strobe. If a leading bit is not zero, the frame is flagged as a framing error and no result is published.

After each frame the controller holds chip select high for a programmable quiet interval, so the converter has time to acquire its next sample. It can also send a sleep frame. This frame raises chip select early, after a parameterised number of serial clock falling edges, and that puts the converter into power-down. A wake command then runs a full-length dummy frame whose data is thrown away. A convert command issued while the converter is asleep does the same thing: it wakes the converter and returns no result. The frame after that one delivers valid data.

Top module: `adc_serial_rdr`

## Requirements
- R1: While reset is held and after it is released, cs_n and sclk are high, and busy, result_valid and frame_err are low. result reads 0.
- R2: A convert command taken in idle drives cs_n low on the next clock, and busy is high from that cycle. The frame has exactly 16 sclk falling edges. sclk is high whenever cs_n is high, including the cycles where cs_n falls and rises.
- R3: The data line is sampled on each sclk falling edge. The bits from falling edges 5 to 16 become result bits 11 down to 0 (most significant first). The bits from edges 1 to 4 are the leading bits.
- R4: result[15:0] is the 12-bit two's-complement code sign-extended to 16 bits (code 0x7FF gives 0x07FF, code 0x800 gives 0xF800). result_valid is high for exactly one clock per good read frame. result changes only in a cycle where result_valid is high.
- R5: If any of the four leading bits is 1, frame_err pulses for one clock, result_valid stays low and result keeps its previous value.
- R6: After cs_n rises, busy stays high for QUIET_CYC clocks. cs_n does not fall again until it has been high for at least QUIET_CYC+1 clocks. When commands are presented continuously, the gap is exactly QUIET_CYC+1.
- R7: A sleep command (cmd_op = 1) runs a frame with PD_FALLS sclk falling edges (default 4, allowed range 2 to 9), then raises cs_n. It produces neither result_valid nor frame_err.
- R8: A wake command (cmd_op = 2) runs a full 16-edge frame whose data is discarded: no result_valid, no frame_err, and result is unchanged.
- R9: A convert command (cmd_op = 0) that follows a sleep frame, with no full frame in between, acts as the wake frame: its data is discarded. The next convert returns a valid result.
- R10: Commands presented while busy is high are ignored, and so is cmd_op = 3 in idle. Neither one starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present; taken only when busy is low |
| cmd_op | input | 2 | 0 convert, 1 sleep, 2 wake, 3 ignored |
| busy | output | 1 | High from the chip-select fall until the quiet interval ends |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sdata | input | 1 | Serial data from the converter |
| result | output | 16 | Sign-extended conversion result |
| result_valid | output | 1 | One-cycle strobe for a new result |
| frame_err | output | 1 | One-cycle strobe for nonzero leading bits |

## Verification
The bench converts codes at both full-scale ends, at zero and at mixed bit patterns. A design with a swapped bit order or a missing sign extension returns wrong words, for example 0x0800 in place of 0xF800. It holds the command line high so that frames run back to back, and it measures the chip-select gap and the busy tail; an off-by-one quiet counter shows up as a gap of QUIET_CYC or QUIET_CYC+2. It drives the sleep, wake and asleep-convert sequences against a converter model that sends all ones in its dummy frame. A design that trusts the dummy data then raises a framing error or publishes a bogus result. It also sends commands during a frame, and a design that does not ignore them starts an extra frame.

// File: rtl/adc_rdr_pkg.sv
package adc_rdr_pkg;

  typedef enum logic [1:0] {
    OP_CONV  = 2'd0,
    OP_SLEEP = 2'd1,
    OP_WAKE  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_QUIET = 2'd2
  } state_e;

  typedef enum logic [1:0] {
    FK_READ  = 2'd0,
    FK_DUMMY = 2'd1,
    FK_SLEEP = 2'd2
  } kind_e;

endpackage

// File: rtl/adc_rdr_sclkgen.sv
module adc_rdr_sclkgen #(
  parameter int DIV_HALF   = 2,
  parameter int FRAME_BITS = 16,
  localparam int FB_W      = $clog2(FRAME_BITS + 1),
  localparam int CNT_W     = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1,
  localparam int TOG_W     = $clog2(2 * FRAME_BITS + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [FB_W-1:0] n_falls,
  output logic            sclk,
  output logic            fall_ev,
  output logic            end_ev
);

  logic [CNT_W-1:0] div_q, div_d;
  logic [TOG_W-1:0] tog_q, tog_d;
  logic             sclk_q, sclk_d;
  logic [TOG_W-1:0] tog_last;
  logic             tick;

  assign tog_last = TOG_W'(n_falls) << 1;
  assign tick     = run && (div_q == CNT_W'(DIV_HALF - 1));
  assign fall_ev  = tick && sclk_q && (tog_q < tog_last);
  assign end_ev   = tick && (tog_q == tog_last);
  assign sclk     = sclk_q;

  // next-state
  always_comb begin
    div_d  = div_q;
    tog_d  = tog_q;
    sclk_d = sclk_q;
    if (!run) begin
      div_d  = '0;
      tog_d  = '0;
      sclk_d = 1'b1;
    end else if (tick) begin
      div_d = '0;
      if (tog_q < tog_last) begin
        tog_d  = tog_q + 1'b1;
        sclk_d = ~sclk_q;
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tog_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      div_q  <= div_d;
      tog_q  <= tog_d;
      sclk_q <= sclk_d;
    end
  end

endmodule

// File: rtl/adc_rdr_deser.sv
module adc_rdr_deser #(
  parameter int LEAD_BITS  = 4,
  parameter int DATA_BITS  = 12,
  localparam int FRAME_BITS = LEAD_BITS + DATA_BITS,
  localparam int BC_W       = $clog2(FRAME_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 fall_ev,
  input  logic                 sdata,
  output logic                 word_done,
  output logic                 lead_ok,
  output logic [DATA_BITS-1:0] data
);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [BC_W-1:0]       bc_q, bc_d;
  logic                  done_q, done_d;

  // next-state
  always_comb begin
    sh_d   = sh_q;
    bc_d   = bc_q;
    done_d = 1'b0;
    if (start) begin
      bc_d = '0;
    end else if (fall_ev) begin
      sh_d   = {sh_q[FRAME_BITS-2:0], sdata};
      bc_d   = bc_q + 1'b1;
      done_d = (bc_q == BC_W'(FRAME_BITS - 1));
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bc_q   <= bc_d;
      done_q <= done_d;
    end
  end

  assign word_done = done_q;
  assign lead_ok   = (sh_q[FRAME_BITS-1 -: LEAD_BITS] == '0);
  assign data      = sh_q[DATA_BITS-1:0];

endmodule

// File: rtl/adc_rdr_seq.sv
module adc_rdr_seq
  import adc_rdr_pkg::*;
#(
  parameter int QUIET_CYC  = 8,
  parameter int FRAME_BITS = 16,
  parameter int PD_FALLS   = 4,
  localparam int FB_W      = $clog2(FRAME_BITS + 1),
  localparam int Q_W       = $clog2(QUIET_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic            end_ev,
  output logic            run,
  output logic            start,
  output logic            busy,
  output logic [FB_W-1:0] n_falls,
  output kind_e           kind
);

  state_e         st_q, st_d;
  kind_e          kind_q, kind_d;
  logic           asleep_q, asleep_d;
  logic [Q_W-1:0] q_q, q_d;
  op_e            op;
  logic           accept;

  assign op     = op_e'(cmd_op);
  assign accept = (st_q == ST_IDLE) && cmd_valid && (op != OP_NONE);

  // next-state
  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    asleep_d = asleep_q;
    q_d      = q_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d = ST_FRAME;
          unique case (op)
            OP_SLEEP: kind_d = FK_SLEEP;
            OP_WAKE:  kind_d = FK_DUMMY;
            default:  kind_d = asleep_q ? FK_DUMMY : FK_READ;
          endcase
        end
      end
      ST_FRAME: begin
        if (end_ev) begin
          st_d     = ST_QUIET;
          q_d      = '0;
          asleep_d = (kind_q == FK_SLEEP);
        end
      end
      ST_QUIET: begin
        if (q_q == Q_W'(QUIET_CYC - 1)) st_d = ST_IDLE;
        else                            q_d  = q_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      kind_q   <= FK_READ;
      asleep_q <= 1'b0;
      q_q      <= '0;
    end else begin
      st_q     <= st_d;
      kind_q   <= kind_d;
      asleep_q <= asleep_d;
      q_q      <= q_d;
    end
  end

  assign run     = (st_q == ST_FRAME);
  assign start   = accept;
  assign busy    = (st_q != ST_IDLE);
  assign n_falls = (kind_q == FK_SLEEP) ? FB_W'(PD_FALLS) : FB_W'(FRAME_BITS);
  assign kind    = kind_q;

endmodule

// File: rtl/adc_serial_rdr.sv
module adc_serial_rdr
  import adc_rdr_pkg::*;
#(
  parameter int DIV_HALF  = 2,
  parameter int QUIET_CYC = 8,
  parameter int LEAD_BITS = 4,
  parameter int DATA_BITS = 12,
  parameter int OUT_W     = 16,
  parameter int PD_FALLS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  output logic             busy,
  output logic             cs_n,
  output logic             sclk,
  input  logic             sdata,
  output logic [OUT_W-1:0] result,
  output logic             result_valid,
  output logic             frame_err
);

  localparam int FRAME_BITS = LEAD_BITS + DATA_BITS;
  localparam int FB_W       = $clog2(FRAME_BITS + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic                 run, start, fall_ev, end_ev;
  logic                 word_done, lead_ok;
  logic [FB_W-1:0]      n_falls;
  logic [DATA_BITS-1:0] data;
  kind_e                kind;

  adc_rdr_seq #(
    .QUIET_CYC (QUIET_CYC),
    .FRAME_BITS(FRAME_BITS),
    .PD_FALLS  (PD_FALLS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .end_ev   (end_ev),
    .run      (run),
    .start    (start),
    .busy     (busy),
    .n_falls  (n_falls),
    .kind     (kind)
  );

  adc_rdr_sclkgen #(
    .DIV_HALF  (DIV_HALF),
    .FRAME_BITS(FRAME_BITS)
  ) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_s_q),
    .run    (run),
    .n_falls(n_falls),
    .sclk   (sclk),
    .fall_ev(fall_ev),
    .end_ev (end_ev)
  );

  adc_rdr_deser #(
    .LEAD_BITS(LEAD_BITS),
    .DATA_BITS(DATA_BITS)
  ) u_deser (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .start    (start),
    .fall_ev  (fall_ev),
    .sdata    (sdata),
    .word_done(word_done),
    .lead_ok  (lead_ok),
    .data     (data)
  );

  assign cs_n = ~run;

  // sign extension of the two's-complement code
  logic [OUT_W-1:0] wide;
  generate
    if (OUT_W > DATA_BITS) begin : g_ext
      assign wide = {{(OUT_W - DATA_BITS){data[DATA_BITS-1]}}, data};
    end else begin : g_cut
      assign wide = data[OUT_W-1:0];
    end
  endgenerate

  logic [OUT_W-1:0] res_q, res_d;
  logic             vld_q, vld_d, err_q, err_d;
  logic             is_read;

  assign is_read = (kind == FK_READ);

  // next-state
  always_comb begin
    res_d = res_q;
    vld_d = 1'b0;
    err_d = 1'b0;
    if (word_done && is_read) begin
      if (lead_ok) begin
        res_d = wide;
        vld_d = 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      res_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign result       = res_q;
  assign result_valid = vld_q;
  assign frame_err    = err_q;

endmodule

// File: rtl/adc_serial_rdr_chk.sv
module adc_serial_rdr_chk #(
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12,
  parameter int OUT_W      = 16,
  parameter int QUIET_CYC  = 8,
  parameter int PD_FALLS   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             busy,
  input logic [OUT_W-1:0] result,
  input logic             result_valid,
  input logic             frame_err
);

  localparam int FC_W  = $clog2(FRAME_BITS + 2);
  localparam int GAP_W = $clog2(QUIET_CYC + 3) + 1;
  localparam int GAP_T = QUIET_CYC + 1;

  logic             sclk_d;
  logic [FC_W-1:0]  fcnt;
  logic [GAP_W-1:0] gap;
  logic             seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      fcnt   <= '0;
      gap    <= '0;
      seen   <= 1'b0;
    end else begin
      sclk_d <= sclk;
      if (cs_n)                fcnt <= '0;
      else if (sclk_d && !sclk) fcnt <= fcnt + 1'b1;
      if (!cs_n)                         gap <= '0;
      else if (gap != GAP_W'(GAP_T + 1)) gap <= gap + 1'b1;
      if (!cs_n) seen <= 1'b1;
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk); // R2

  AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R2

  AST_FRAME_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (fcnt == FC_W'(FRAME_BITS) || fcnt == FC_W'(PD_FALLS))); // R7

  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && seen) |-> (gap >= GAP_W'(GAP_T))); // R6

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid); // R4

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result)); // R4

  AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !result_valid); // R5

  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (result[OUT_W-1] == result[DATA_BITS-1])); // R4

endmodule

bind adc_serial_rdr adc_serial_rdr_chk #(
  .FRAME_BITS(LEAD_BITS + DATA_BITS),
  .DATA_BITS (DATA_BITS),
  .OUT_W     (OUT_W),
  .QUIET_CYC (QUIET_CYC),
  .PD_FALLS  (PD_FALLS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .sclk        (sclk),
  .busy        (busy),
  .result      (result),
  .result_valid(result_valid),
  .frame_err   (frame_err)
);

// File: tb/adc_serial_rdr_tb.sv
module adc_serial_rdr_tb;

  localparam int CLK_P    = 10;
  localparam int QUIET    = 8;
  localparam int PD_FALLS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        busy, cs_n, sclk, sdata;
  logic [15:0] result;
  logic        result_valid, frame_err;

  always #(CLK_P / 2) clk = ~clk;

  adc_serial_rdr #(
    .DIV_HALF(2), .QUIET_CYC(QUIET), .LEAD_BITS(4),
    .DATA_BITS(12), .OUT_W(16), .PD_FALLS(PD_FALLS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .result(result), .result_valid(result_valid), .frame_err(frame_err)
  );

  // converter model: shifts on sclk falls, sleeps on an early cs_n rise
  logic [11:0] m_code = 12'h000;
  logic [3:0]  m_lead = 4'h0;
  logic [15:0] m_sh = 16'h0;
  logic        m_oe = 1'b0;
  logic        m_asleep = 1'b0;
  int          m_falls = 0;

  always @(negedge cs_n) begin
    m_sh    = m_asleep ? 16'hFFFF : {m_lead, m_code};
    m_falls = 0;
    m_oe    = 1'b1;
  end
  always @(negedge sclk) if (cs_n === 1'b0) begin
    m_falls = m_falls + 1;
    m_sh    = m_sh << 1;
    if (m_falls == 16) m_oe = 1'b0;
  end
  always @(posedge cs_n) begin
    if (m_falls >= 2 && m_falls < 10) m_asleep = 1'b1;
    else if (m_falls == 16)           m_asleep = 1'b0;
    m_oe = 1'b0;
  end
  assign sdata = m_oe ? m_sh[15] : 1'b1;

  // monitors, sampled away from the active edge
  int frames = 0, last_falls = 0, mon_falls = 0;
  int n_valid = 0, n_err = 0, gap = 0, last_gap = 0, bq = 0, last_bq = 0;
  logic [15:0] last_res = 16'h0;

  always @(negedge cs_n) frames = frames + 1;
  always @(negedge sclk) if (cs_n === 1'b0) mon_falls = mon_falls + 1;
  always @(posedge cs_n) begin last_falls = mon_falls; mon_falls = 0; end
  always @(negedge clk) if (rst_n) begin
    if (result_valid) begin n_valid = n_valid + 1; last_res = result; end
    if (frame_err) n_err = n_err + 1;
    if (cs_n) begin
      gap = gap + 1;
      if (busy) bq = bq + 1;
    end else begin
      if (gap != 0) begin last_gap = gap; last_bq = bq; end
      gap = 0; bq = 0;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  function automatic int sx(input logic [11:0] c);
    return int'({{4{c[11]}}, c});
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic do_cmd(input logic [1:0] op);
    wait_idle();
    cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    wait_idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cs_n === 1'b1, "R1 cs_n", cs_n, 1);
    chk(sclk === 1'b1, "R1 sclk", sclk, 1);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(result_valid === 1'b0 && frame_err === 1'b0, "R1 strobes", {result_valid, frame_err}, 0);
    chk(result === 16'h0, "R1 result", result, 0);
  endtask

  task automatic t_convert(input logic [11:0] code);
    int v0 = n_valid, e0 = n_err;
    m_code = code; m_lead = 4'h0;
    wait_idle();
    cmd_op = 2'd0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cs_n === 1'b0 && busy === 1'b1, "R2 cs_n low and busy after command", {cs_n, busy}, 1);
    @(negedge clk);
    wait_idle();
    @(negedge clk);
    chk(last_falls == 16, "R2 sclk falls per frame", last_falls, 16);
    chk(n_valid == v0 + 1 && n_err == e0, "R4 one valid strobe", n_valid - v0, 1);
    chk(last_res == 16'(sx(code)), "R3 R4 sign-extended result", last_res, sx(code) & 16'hFFFF);
  endtask

  task automatic t_lead_err();
    logic [15:0] keep = result;
    int v0 = n_valid, e0 = n_err;
    m_code = 12'h3C3; m_lead = 4'b0010;
    do_cmd(2'd0);
    chk(n_err == e0 + 1, "R5 frame_err pulse", n_err - e0, 1);
    chk(n_valid == v0, "R5 no valid on bad lead", n_valid - v0, 0);
    chk(result == keep, "R5 result kept", result, keep);
    m_lead = 4'b1000;
    do_cmd(2'd0);
    chk(n_err == e0 + 2 && n_valid == v0, "R5 first lead bit set", n_err - e0, 2);
    m_lead = 4'h0;
  endtask

  task automatic t_quiet();
    int f0 = frames, v0 = n_valid;
    m_code = 12'h5A5;
    wait_idle();
    cmd_op = 2'd0; cmd_valid = 1'b1;
    for (int i = 0; i < 2000 && frames < f0 + 2; i++) @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    wait_idle();
    @(negedge clk);
    chk(last_gap == QUIET + 1, "R6 back-to-back cs_n gap", last_gap, QUIET + 1);
    chk(last_bq == QUIET, "R6 busy tail after cs_n rise", last_bq, QUIET);
    chk(n_valid == v0 + 2, "R6 two results back to back", n_valid - v0, 2);
  endtask

  task automatic t_sleep_wake();
    int v0 = n_valid, e0 = n_err;
    logic [15:0] keep = result;
    do_cmd(2'd1);
    chk(last_falls == PD_FALLS, "R7 sleep frame length", last_falls, PD_FALLS);
    chk(n_valid == v0 && n_err == e0, "R7 sleep frame silent", n_valid - v0, 0);
    do_cmd(2'd2);
    chk(last_falls == 16, "R8 wake frame length", last_falls, 16);
    chk(n_valid == v0 && n_err == e0 && result == keep, "R8 wake data discarded", result, keep);
    t_convert(12'h6B1);
  endtask

  task automatic t_conv_asleep();
    int v0, e0;
    do_cmd(2'd1);
    v0 = n_valid; e0 = n_err;
    m_code = 12'h222;
    do_cmd(2'd0);
    chk(last_falls == 16, "R9 asleep convert runs full frame", last_falls, 16);
    chk(n_valid == v0 && n_err == e0, "R9 asleep convert discarded", n_valid - v0, 0);
    t_convert(12'h9E7);
  endtask

  task automatic t_ignore();
    int f0 = frames;
    wait_idle();
    cmd_op = 2'd3; cmd_valid = 1'b1;
    repeat (20) @(negedge clk);
    cmd_valid = 1'b0;
    chk(frames == f0 && cs_n === 1'b1, "R10 op 3 ignored", frames - f0, 0);
    cmd_op = 2'd0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    cmd_op = 2'd1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(frames == f0 + 1, "R10 command while busy ignored", frames - f0, 1);
    chk(last_falls == 16, "R10 running frame not cut short", last_falls, 16);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_convert(12'h7FF);
    t_convert(12'h800);
    t_convert(12'h000);
    t_convert(12'hFFF);
    t_convert(12'h123);
    t_convert(12'hA5C);
    t_lead_err();
    t_quiet();
    t_sleep_wake();
    t_conv_asleep();
    t_ignore();
    summary();
    $finish;
  end

endmodule